// File: doc/BRIEF.md
# Packed Two-Bit Pixel Serializer

This block turns a stream of 32-bit words into a timed sequence of 2-bit colour values for a raster display. Every input word packs fifteen pixels into its upper thirty bits. The block buffers one word at a time and waits for a one-cycle line-start pulse from a separate sync generator. It then plays out the configured number of pixels back to back, and each pixel stays on the colour bus for a fixed number of system clocks. Outside a line the colour bus sits at zero.

Packing runs straight across line ends. If a line stops partway through a word, the next line starts with the first pixel of that word that has not been shown yet. When a pixel is due and no word is buffered or offered, the block shows zero for that pixel and raises a sticky underflow flag. It consumes nothing from the stream in that case.

Top module: `pix2_serializer`

## Requirements
- R1: Within a word, the first pixel shown comes from bits 31:30, the next from bits 29:28, and so on down to bits 3:2. Bits 1:0 never reach the colour bus.
- R2: A word is accepted only when the buffer is empty, or when its last pixel is being taken in that cycle. While any other buffered pixel remains, s_ready is low.
- R3: A line_start sampled at one clock edge puts the first pixel of the line on the bus at the next edge. Every pixel then stays for exactly CLK_PER_PIX clocks. CLK_PER_PIX is a parameter, 6 by default, at least 2.
- R4: A line shows exactly the captured width of pixels with no gaps. The bus returns to zero at the edge that ends the last pixel's hold.
- R5: The colour bus is zero whenever no line is being shown.
- R6: Pixels left in a partly used word at the end of a line open the next line in their original order.
- R7: line_width is captured at the first line_start after reset and used for every later line. Later changes on the input have no effect.
- R8: A line_start that arrives while a line is being shown is ignored.
- R9: A pixel that is due when no word is buffered or offered shows as zero and sets underflow. underflow stays set until reset, and no stream data is consumed for that pixel.
- R10: After reset the colour bus is zero, underflow is low and s_ready is high.
- R11: A captured width of zero makes every line_start produce no pixels. The bus stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 32 | Packed pixel word |
| s_valid | input | 1 | s_data is offered |
| s_ready | output | 1 | Block accepts s_data this cycle |
| line_width | input | LW_W | Pixels per line, captured once |
| line_start | input | 1 | Pulse: start of an active line |
| pix_out | output | 2 | Colour bus |
| underflow | output | 1 | Sticky: a pixel was due with no data |

## Verification
The bench sweeps every width a 6-bit setting allows. For each width it runs three lines from a continuous stream, so lines shorter than a word, lines equal to a word and lines spanning several words all occur. Only this sweep tells correct carry-over between lines apart from restarting at a word boundary. A bit-order error or a one-pixel slip also shows up, because the pixel sequence is not periodic within a word. Widths changed after the first line and retriggers during a line separate one-time capture from re-sampling. A run with the stream held off separates the underflow path from a stalled pointer, and the lines that follow show whether a pixel was consumed anyway.

// File: rtl/pix2_pkg.sv
package pix2_pkg;
    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_SHOW = 1'b1
    } line_state_e;
endpackage

// File: rtl/pix2_word_buf.sv
module pix2_word_buf #(
    parameter int DATA_W       = 32,
    parameter int PIX_W        = 2,
    parameter int PIX_PER_WORD = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              underflow_o
);
    localparam int PAY_W = PIX_W * PIX_PER_WORD;
    localparam int CNT_W = $clog2(PIX_PER_WORD + 1);

    typedef struct packed {
        logic [PAY_W-1:0] word;
        logic [CNT_W-1:0] rem;
        logic             under;
    } buf_t;

    buf_t d, q;
    logic load;

    generate
        if (DATA_W > PAY_W) begin : g_tail
            logic unused_tail;
            assign unused_tail = ^in_data[DATA_W-PAY_W-1:0];
        end
    endgenerate

    always_comb begin
        d        = q;
        pix_o    = '0;
        in_ready = (q.rem == '0) || ((q.rem == CNT_W'(1)) && take_i);
        load     = in_valid && in_ready;
        if (take_i) begin
            if (q.rem != '0) begin
                pix_o  = q.word[PAY_W-1 -: PIX_W];
                d.word = q.word << PIX_W;
                d.rem  = q.rem - 1'b1;
            end else if (in_valid) begin
                pix_o = in_data[DATA_W-1 -: PIX_W];
            end else begin
                d.under = 1'b1;
            end
        end
        if (load) begin
            if (take_i && (q.rem == '0)) begin
                d.word = in_data[DATA_W-1 -: PAY_W] << PIX_W;
                d.rem  = CNT_W'(PIX_PER_WORD - 1);
            end else begin
                d.word = in_data[DATA_W-1 -: PAY_W];
                d.rem  = CNT_W'(PIX_PER_WORD);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign underflow_o = q.under;

    // R2
    word_load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (q.rem >= CNT_W'(PIX_PER_WORD - 1)));

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && q.rem != '0) |=> $stable(q.rem) && $stable(q.word));

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

    // R9
    underflow_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && q.rem == '0 && !in_valid) |=> (q.rem == '0) && underflow_o);
endmodule

// File: rtl/pix2_line_ctrl.sv
module pix2_line_ctrl
    import pix2_pkg::*;
#(
    parameter int PIX_W       = 2,
    parameter int CLK_PER_PIX = 6,
    parameter int LW_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [LW_W-1:0]  line_width,
    output logic             take_o,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             busy_o
);
    localparam int HOLD_W = (CLK_PER_PIX > 2) ? $clog2(CLK_PER_PIX) : 1;

    typedef struct packed {
        line_state_e       st;
        logic              loaded;
        logic [LW_W-1:0]   width;
        logic [LW_W-1:0]   left;
        logic [HOLD_W-1:0] hold;
        logic [PIX_W-1:0]  pix;
    } ctl_t;

    ctl_t d, q;

    always_comb begin
        d      = q;
        take_o = 1'b0;
        unique case (q.st)
            LN_IDLE: begin
                if (line_start) begin
                    d.st   = LN_SHOW;
                    d.hold = '0;
                    if (!q.loaded) begin
                        d.loaded = 1'b1;
                        d.width  = line_width;
                        d.left   = line_width;
                    end else begin
                        d.left = q.width;
                    end
                end
            end
            LN_SHOW: begin
                if (q.hold == '0) begin
                    if (q.left == '0) begin
                        d.st  = LN_IDLE;
                        d.pix = '0;
                    end else begin
                        take_o = 1'b1;
                        d.pix  = pix_i;
                        d.left = q.left - 1'b1;
                        d.hold = HOLD_W'(CLK_PER_PIX - 1);
                    end
                end else begin
                    d.hold = q.hold - 1'b1;
                end
            end
            default: d.st = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_o  = q.pix;
    assign busy_o = (q.st == LN_SHOW);

    // R3
    pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.hold != '0) |=> $stable(pix_o));

    // R7
    width_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.loaded |=> $stable(q.width) && q.loaded);

    // R8
    retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.hold != '0) |=> $stable(q.left));

    // R4
    take_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (q.left != '0) && busy_o);
endmodule

// File: rtl/pix2_serializer.sv
module pix2_serializer #(
    parameter int DATA_W       = 32,
    parameter int PIX_W        = 2,
    parameter int PIX_PER_WORD = 15,
    parameter int CLK_PER_PIX  = 6,
    parameter int LW_W         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [LW_W-1:0]   line_width,
    input  logic              line_start,
    output logic [PIX_W-1:0]  pix_out,
    output logic              underflow
);
    logic             take;
    logic [PIX_W-1:0] next_pix;
    logic             busy;

    pix2_word_buf #(
        .DATA_W       (DATA_W),
        .PIX_W        (PIX_W),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) i_word_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (s_data),
        .in_valid    (s_valid),
        .in_ready    (s_ready),
        .take_i      (take),
        .pix_o       (next_pix),
        .underflow_o (underflow)
    );

    pix2_line_ctrl #(
        .PIX_W       (PIX_W),
        .CLK_PER_PIX (CLK_PER_PIX),
        .LW_W        (LW_W)
    ) i_line_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_width (line_width),
        .take_o     (take),
        .pix_i      (next_pix),
        .pix_o      (pix_out),
        .busy_o     (busy)
    );

    // R5
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pix_out == '0));

    // R3
    first_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_start) |=> busy);
endmodule

// File: tb/test_pix2_serializer.sv
module test_pix2_serializer;
    localparam int C  = 3;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [LW-1:0] line_width = '0;
    logic          line_start = 1'b0;
    logic [1:0]    pix_out;
    logic          underflow;

    int  n_chk = 0;
    int  n_fail = 0;
    int  widx = 0;
    bit  hs = 1'b0;
    bit  feed_en = 1'b0;
    int  gp = 0;

    always #2 clk = ~clk;

    pix2_serializer #(.CLK_PER_PIX(C), .LW_W(LW)) i_pix2_serializer (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .line_width(line_width), .line_start(line_start),
        .pix_out(pix_out), .underflow(underflow)
    );

    function automatic logic [1:0] seq(input int n);
        return 2'((n * 5 + (n >> 3)) & 3);
    endfunction

    function automatic logic [31:0] mkword(input int idx);
        logic [31:0] w;
        w = 32'h3;
        for (int j = 0; j < 15; j++) w[31-2*j -: 2] = seq(15 * idx + j);
        return w;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            widx = 0;
            hs   = 1'b0;
        end else if (hs) begin
            widx = widx + 1;
        end
        s_data  = mkword(widx);
        s_valid = feed_en;
        hs      = s_valid && s_ready && rst_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int w);
        feed_en = 1'b0;
        rst_n = 1'b0;
        line_width = LW'(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gp = 0;
    endtask

    // Runs one line; starved: expect zeros and no consumption.
    task automatic run_line(input int w, input bit retrig, input bit starved);
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        for (int i = 0; i < w; i++) begin
            for (int c = 0; c < C; c++) begin
                @(negedge clk);
                if (retrig && i == 1) line_start = (c == 0);
                chk("R1 R3 R6 R8 R9 pixel", pix_out, starved ? 0 : int'(seq(gp + i)));
            end
        end
        line_start = 1'b0;
        @(negedge clk);
        chk("R4 R5 R11 end zero", pix_out, 0);
        if (!starved) gp += w;
        repeat (2) @(negedge clk);
        chk("R5 gap zero", pix_out, 0);
    endtask

    initial begin
        do_reset(4);
        chk("R10 pix reset", pix_out, 0);
        chk("R10 underflow reset", underflow, 0);
        chk("R10 ready reset", s_ready, 1);
        feed_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 ready low with full word", s_ready, 0);

        for (int w = 0; w < (1 << LW); w++) begin
            do_reset(w);
            feed_en = 1'b1;
            repeat (3) @(negedge clk);
            run_line(w, 1'b0, 1'b0);
            line_width = LW'(w + 5);
            run_line(w, (w >= 3), 1'b0);
            run_line(w, 1'b0, 1'b0);
            chk("R2 words taken", widx, gp / 15 + 1);
            chk("R9 no underflow when fed", underflow, 0);
        end

        do_reset(3);
        repeat (2) @(negedge clk);
        run_line(3, 1'b0, 1'b1);
        chk("R9 underflow set", underflow, 1);
        chk("R9 no word consumed", widx, 0);
        feed_en = 1'b1;
        repeat (3) @(negedge clk);
        run_line(3, 1'b0, 1'b0);
        chk("R9 underflow sticky", underflow, 1);
        run_line(3, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule